// File: doc/BRIEF.md
# Interrupt Acknowledge Sequencer

This block answers an interrupt request by obtaining the 8-bit interrupt type. When the type comes from an external interrupt controller, the block makes two acknowledge bus cycles. The bus is locked for both cycles, and the block reads the type from the low data byte during the second cycle only. When the on-chip controller supplies the type, the block makes no bus cycles. It hands the internal type straight to its output.

The block waits in `S_IDLE` for `req_i`. With `ext_src_i` high, it moves through `S_A1_T1` → `S_A1_T2` → `S_A1_T3`. It stays in `S_A1_TW` while READY is low, then goes to `S_A1_T4`. Next come the two forced idle states `S_GAP1` → `S_GAP2`. The second cycle repeats the pattern: `S_A2_T1` → `S_A2_T2` → `S_A2_T3` / `S_A2_TW` → `S_A2_T4`. The block then enters `S_FIN`, which gives a one-cycle done pulse, and returns to `S_IDLE`. With `ext_src_i` low, the request goes from `S_IDLE` straight to `S_FIN`. Each state maps to the output pins through a single decoder.

Top module: `intack_seq`

## Requirements
- R1: After reset, and whenever idle: `ale_o`=0, `rd_n_o`=1, `inta_n_o`=1, `lock_n_o`=1, `status_o`=3'b111, `done_o`=0, `type_o`=0.
- R2: Internal source (`ext_src_i`=0):
  - `done_o` is high in the cycle right after the request edge.
  - `type_o` then equals the `int_type_i` value sampled at that edge.
  - The block makes no bus cycle: `ale_o`=0, `inta_n_o`=1, `lock_n_o`=1.
- R3: External source: the block makes exactly two acknowledge cycles, each in the order T1, T2, T3, T4. `ale_o` is high only in the T1 cycle of each.
- R4: `inta_n_o` is low from T2 through T3 of each acknowledge cycle, and through any wait states.
- R5: Exactly two idle cycles separate the first T4 from the second T1. During them `ale_o`=0, `inta_n_o`=1 and `status_o`=3'b111.
- R6: `lock_n_o` is low from the first T1 through the second T4, including the idle cycles.
- R7: `rd_n_o` stays high throughout both acknowledge cycles.
- R8: `ready_i` is sampled at the end of T3 and of every wait cycle. While it is low, wait cycles are added with `inta_n_o` held low.
- R9: `type_o` takes `ad_i[7:0]` at the edge where ready is seen in the second cycle. The data byte in the first cycle is ignored. `type_o` holds until the next completion.
- R10: `done_o` is a one-cycle pulse in the cycle after the second T4, and `lock_n_o` is already high in that cycle. The done cycle comes 11 + w1 + w2 cycles after the request edge, where w1 and w2 are the wait counts of the two cycles.
- R11: `req_i` is ignored while a sequence is in progress.
- R12: `status_o` is 3'b000 during T1 to T3 and the wait states of each acknowledge cycle, and 3'b111 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Interrupt service request |
| ext_src_i | input | 1 | 1: type from external controller, 0: internal |
| int_type_i | input | 8 | Type from the internal controller |
| ready_i | input | 1 | Bus ready |
| ad_i | input | 8 | Low address/data byte |
| ale_o | output | 1 | Address latch enable |
| rd_n_o | output | 1 | Read strobe, active low |
| inta_n_o | output | 1 | Acknowledge strobe, active low |
| lock_n_o | output | 1 | Bus lock, active low |
| status_o | output | 3 | Bus status code |
| done_o | output | 1 | Type valid pulse |
| type_o | output | 8 | Captured interrupt type |

## Verification
The assertions check these rules on every cycle:
- `ale_o` and `done_o` last exactly one cycle, and `inta_n_o` follows `ale_o`.
- The strobe stays low while ready is low.
- The lock covers every strobe cycle and is released by the done cycle.
- The status code is ack whenever the strobe is low.
- `type_o` moves only while locked or at done.

Other properties need the bench's sweeps over every pairing of zero to three wait states in each cycle, and over all 256 internal types:
- the exact length of the idle gap,
- the total latency,
- that the first cycle's data byte is ignored,
- that requests made mid-sequence are ignored.

// File: rtl/intack_pkg.sv
package intack_pkg;
    localparam int TYPE_W = 8;
    localparam int STAT_W = 3;
    localparam logic [STAT_W-1:0] ST_ACK     = 3'b000;
    localparam logic [STAT_W-1:0] ST_PASSIVE = 3'b111;

    typedef enum logic [3:0] {
        S_IDLE,
        S_A1_T1, S_A1_T2, S_A1_T3, S_A1_TW, S_A1_T4,
        S_GAP1,  S_GAP2,
        S_A2_T1, S_A2_T2, S_A2_T3, S_A2_TW, S_A2_T4,
        S_FIN
    } seq_state_t;
endpackage

// File: rtl/intack_fsm.sv
module intack_fsm
    import intack_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       req_i,
    input  logic       ext_src_i,
    input  logic       ready_i,
    output seq_state_t state_o
);
    seq_state_t state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:  if (req_i) state_d = ext_src_i ? S_A1_T1 : S_FIN;
            S_A1_T1: state_d = S_A1_T2;
            S_A1_T2: state_d = S_A1_T3;
            S_A1_T3: state_d = ready_i ? S_A1_T4 : S_A1_TW;
            S_A1_TW: state_d = ready_i ? S_A1_T4 : S_A1_TW;
            S_A1_T4: state_d = S_GAP1;
            S_GAP1:  state_d = S_GAP2;
            S_GAP2:  state_d = S_A2_T1;
            S_A2_T1: state_d = S_A2_T2;
            S_A2_T2: state_d = S_A2_T3;
            S_A2_T3: state_d = ready_i ? S_A2_T4 : S_A2_TW;
            S_A2_TW: state_d = ready_i ? S_A2_T4 : S_A2_TW;
            S_A2_T4: state_d = S_FIN;
            S_FIN:   state_d = S_IDLE;
            default: state_d = S_IDLE;
        endcase
    end

    assign state_o = state_q;
endmodule

// File: rtl/intack_decode.sv
module intack_decode
    import intack_pkg::*;
(
    input  seq_state_t        state_i,
    output logic              ale_o,
    output logic              rd_n_o,
    output logic              inta_n_o,
    output logic              lock_n_o,
    output logic [STAT_W-1:0] status_o,
    output logic              done_o
);
    always_comb begin
        ale_o    = 1'b0;
        rd_n_o   = 1'b1;
        inta_n_o = 1'b1;
        lock_n_o = 1'b0;
        status_o = ST_PASSIVE;
        done_o   = 1'b0;
        unique case (state_i)
            S_IDLE: lock_n_o = 1'b1;
            S_A1_T1, S_A2_T1: begin
                ale_o    = 1'b1;
                status_o = ST_ACK;
            end
            S_A1_T2, S_A1_T3, S_A1_TW,
            S_A2_T2, S_A2_T3, S_A2_TW: begin
                inta_n_o = 1'b0;
                status_o = ST_ACK;
            end
            S_A1_T4, S_A2_T4, S_GAP1, S_GAP2: ;
            S_FIN: begin
                lock_n_o = 1'b1;
                done_o   = 1'b1;
            end
            default: lock_n_o = 1'b1;
        endcase
    end
endmodule

// File: rtl/intack_capture.sv
module intack_capture
    import intack_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  seq_state_t        state_i,
    input  logic              req_i,
    input  logic              ext_src_i,
    input  logic              ready_i,
    input  logic [TYPE_W-1:0] ad_i,
    input  logic [TYPE_W-1:0] int_type_i,
    output logic [TYPE_W-1:0] type_o
);
    logic load_int, load_ext;
    logic [TYPE_W-1:0] type_q;

    assign load_int = (state_i == S_IDLE) && req_i && !ext_src_i;
    assign load_ext = ((state_i == S_A2_T3) || (state_i == S_A2_TW)) && ready_i;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        type_q <= '0;
        else if (load_int) type_q <= int_type_i;
        else if (load_ext) type_q <= ad_i;
    end

    assign type_o = type_q;
endmodule

// File: rtl/intack_seq.sv
module intack_seq
    import intack_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_i,
    input  logic              ext_src_i,
    input  logic [TYPE_W-1:0] int_type_i,
    input  logic              ready_i,
    input  logic [TYPE_W-1:0] ad_i,
    output logic              ale_o,
    output logic              rd_n_o,
    output logic              inta_n_o,
    output logic              lock_n_o,
    output logic [STAT_W-1:0] status_o,
    output logic              done_o,
    output logic [TYPE_W-1:0] type_o
);
    seq_state_t state;

    intack_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_i     (req_i),
        .ext_src_i (ext_src_i),
        .ready_i   (ready_i),
        .state_o   (state)
    );

    intack_decode u_dec (
        .state_i  (state),
        .ale_o    (ale_o),
        .rd_n_o   (rd_n_o),
        .inta_n_o (inta_n_o),
        .lock_n_o (lock_n_o),
        .status_o (status_o),
        .done_o   (done_o)
    );

    intack_capture u_cap (
        .clk        (clk),
        .rst_n      (rst_n),
        .state_i    (state),
        .req_i      (req_i),
        .ext_src_i  (ext_src_i),
        .ready_i    (ready_i),
        .ad_i       (ad_i),
        .int_type_i (int_type_i),
        .type_o     (type_o)
    );
endmodule

// File: rtl/intack_seq_chk.sv
module intack_seq_chk
    import intack_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              ready_i,
    input logic              ale_o,
    input logic              inta_n_o,
    input logic              lock_n_o,
    input logic [STAT_W-1:0] status_o,
    input logic              done_o,
    input logic [TYPE_W-1:0] type_o
);
    AST_ALE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        ale_o |=> !ale_o); // R3
    AST_ALE_THEN_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        ale_o |=> !inta_n_o); // R4
    AST_WAIT_HOLDS_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        (!inta_n_o && $past(!inta_n_o) && !ready_i) |=> !inta_n_o); // R8
    AST_LOCK_COVERS_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        !inta_n_o |-> !lock_n_o); // R6
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o); // R10
    AST_DONE_UNLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> lock_n_o); // R10
    AST_TYPE_MOVES_IN_SEQ: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(type_o) |-> (done_o || !lock_n_o)); // R9
    AST_STATUS_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        !inta_n_o |-> (status_o == ST_ACK)); // R12
endmodule

bind intack_seq intack_seq_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .ready_i  (ready_i),
    .ale_o    (ale_o),
    .inta_n_o (inta_n_o),
    .lock_n_o (lock_n_o),
    .status_o (status_o),
    .done_o   (done_o),
    .type_o   (type_o)
);

// File: tb/intack_seq_tb.sv
`timescale 1ns/1ps
module intack_seq_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req_i = 1'b0;
    logic       ext_src_i = 1'b0;
    logic [7:0] int_type_i = 8'h00;
    logic       ready_i = 1'b0;
    logic [7:0] ad_i = 8'h00;
    logic       ale_o, rd_n_o, inta_n_o, lock_n_o, done_o;
    logic [2:0] status_o;
    logic [7:0] type_o;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    intack_seq u_dut (
        .clk(clk), .rst_n(rst_n), .req_i(req_i), .ext_src_i(ext_src_i),
        .int_type_i(int_type_i), .ready_i(ready_i), .ad_i(ad_i),
        .ale_o(ale_o), .rd_n_o(rd_n_o), .inta_n_o(inta_n_o),
        .lock_n_o(lock_n_o), .status_o(status_o), .done_o(done_o),
        .type_o(type_o)
    );

    task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h at %0t", tag, what, act, exp, $time);
        end
    endtask

    task automatic idle_chk(string tag);
        chk(tag, "ale", ale_o, 0);
        chk(tag, "rd_n", rd_n_o, 1);
        chk(tag, "inta_n", inta_n_o, 1);
        chk(tag, "lock_n", lock_n_o, 1);
        chk(tag, "status", status_o, 3'b111);
        chk(tag, "done", done_o, 0);
    endtask

    task automatic run_ext(int w1, int w2, logic [7:0] ty, bit hold);
        int kd = 11 + w1 + w2;
        int b  = 6 + w1;
        for (int k = 0; k <= kd + 2; k++) begin
            @(negedge clk);
            if (k >= 1 && k <= kd) begin
                bit t1   = (k == 1) || (k == b + 1);
                bit stb  = (k >= 2 && k <= 3 + w1) || (k >= b + 2 && k <= b + 3 + w2);
                bit wt   = (k > 3 && k <= 3 + w1) || (k > b + 3 && k <= b + 3 + w2);
                bit gap  = (k == b - 1) || (k == b);
                bit lck  = (k <= b + 4 + w2);
                chk(gap ? "R5" : "R3", "ale", ale_o, t1);
                chk(wt ? "R8" : (gap ? "R5" : "R4"), "inta_n", inta_n_o, !stb);
                chk("R6", "lock_n", lock_n_o, !lck);
                chk("R7", "rd_n", rd_n_o, 1);
                chk(gap ? "R5" : "R12", "status", status_o, (t1 || stb) ? 3'b000 : 3'b111);
                chk("R10", "done", done_o, k == kd);
                if (k == kd) chk("R9", "type", type_o, ty);
            end
            if (k > kd) begin
                idle_chk(hold ? "R11" : "R1");
                chk("R9", "type hold", type_o, ty);
            end
            req_i     = (k == 0) || (hold && k < kd);
            ext_src_i = 1'b1;
            ready_i   = (k == 3 + w1) || (k == b + 3 + w2);
            ad_i      = (k == b + 3 + w2) ? ty : ~ty;
        end
        req_i = 1'b0;
        ready_i = 1'b0;
    endtask

    task automatic run_int(logic [7:0] v);
        @(negedge clk);
        req_i = 1'b1; ext_src_i = 1'b0; int_type_i = v; ready_i = 1'b1;
        @(negedge clk);
        chk("R2", "done", done_o, 1);
        chk("R2", "type", type_o, v);
        chk("R2", "ale", ale_o, 0);
        chk("R2", "inta_n", inta_n_o, 1);
        chk("R2", "lock_n", lock_n_o, 1);
        req_i = 1'b0; int_type_i = ~v; ready_i = 1'b0;
        @(negedge clk);
        chk("R2", "done after", done_o, 0);
        chk("R9", "type hold", type_o, v);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        idle_chk("R1");
        chk("R1", "type", type_o, 0);
        rst_n = 1'b1;
        @(negedge clk);
        idle_chk("R1");
        for (int w1 = 0; w1 < 4; w1++)
            for (int w2 = 0; w2 < 4; w2++)
                run_ext(w1, w2, 8'((w1 * 37 + w2 * 91 + 5) & 255), ((w1 + w2) % 2) == 1);
        for (int v = 0; v < 256; v++) run_int(8'(v));
        run_ext(2, 1, 8'hC3, 1'b1);
        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual running expected finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule